// File: doc/BRIEF.md
# Low-Storage Store Guard and Prefix Relocator

This unit sits between address translation and the memory port of a processor core. It takes a real address that is already translated, together with the kind of access, and returns the absolute address to use. On the way it decides whether a store must be refused because it targets the guarded low-storage area. It also builds the exception-code word that a protection fault reports. It also raises a flag that tells the translation cache not to keep write permission for a page that touches the guarded area.

The guarded area is not one block. It is the first 512 bytes of real page 0 and the first 512 bytes of real page 1. The guard is switched on by a control-register bit. When dynamic address translation is on, each address space can also opt out through a private-space bit in its descriptor. Relocation swaps the first 8 KB of real storage with an 8 KB area that the per-CPU prefix register selects, in both directions. Every result is registered one cycle after it is accepted, behind a valid/ready handshake.

Top module: `lowprot_prefix_unit`

## Requirements
- R1: An address is low when it lies in 0..511 or 4096..4607. A store (access code 2'b01) whose full address is low faults with result code 2'b01 when the guard is active. Reads (2'b00), fetches (2'b10) and code 2'b11 never fault. Stores at 512..4095 or at 4608 and above never fault.
- R2: With translation on, the guard is active only when the enable bit is set and the private bit of the selected space is clear. Space codes are 2'b00 primary (uses `in_priv_pri`), 2'b10 secondary (uses `in_priv_sec`) and 2'b11 home (uses `in_priv_home`). The private bits of the other spaces have no effect.
- R3: With translation off, the guard is active exactly when the enable bit is set. The space code and all private bits are then ignored.
- R4: `out_wr_inval` is 1 when the guard is active and the page-aligned address is low, which means real page 0 or 1. This holds whether or not the access faults, including reads and stores at offset 512 and above within those pages.
- R5: `out_tec` bits [63:12] hold the page number of the address. Bit 10 is set for a store and bit 11 for any other access. Bits [1:0] carry the space code when translation is on and are 0 when it is off. Bit 7 is set only for a low-storage protection fault. All other bits are 0.
- R6: The prefix is taken with its low 13 bits forced to 0. An address below 0x2000 becomes address + prefix. An address in [prefix, prefix + 0x2000) becomes address − prefix. Any other address passes through unchanged, with its byte offset kept.
- R7: With translation on, space code 2'b01 is unsupported. It yields result code 2'b10 and `out_wr_inval` = 0, and no protection check is made.
- R8: `out_fault` is 1 exactly when the result code is nonzero. On a fault `out_abs` is 0.
- R9: A result appears on the outputs in the cycle after its input is accepted. It is held unchanged while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R10: After a synchronous reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_addr | input | ADDR_W | Real address |
| in_acc | input | 2 | Access kind: 00 read, 01 store, 10 fetch |
| in_lap_en | input | 1 | Low-storage guard enable bit |
| in_dat_on | input | 1 | Translation mode active |
| in_space | input | 2 | Address-space code |
| in_priv_pri | input | 1 | Private bit of primary descriptor |
| in_priv_sec | input | 1 | Private bit of secondary descriptor |
| in_priv_home | input | 1 | Private bit of home descriptor |
| in_prefix | input | ADDR_W | Prefix register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_abs | output | ADDR_W | Absolute address (0 on fault) |
| out_fault | output | 1 | Any fault |
| out_code | output | 2 | 00 ok, 01 protection, 10 unsupported space |
| out_tec | output | ADDR_W | Exception-code word |
| out_wr_inval | output | 1 | Do not cache write permission |

## Verification
The bench builds the unit with its default values: a 64-bit address, 4 KB pages, a 512-byte guard in each of two pages and an 8 KB prefix granule. With these values the window edges at 511/512 and 4607/4608 lie at fixed, directly reachable addresses. Random prefixes are drawn from a handful of low granules, and random addresses cluster around zero, both window edges and the prefix area. This makes both directions of the swap, the prefix-equals-zero overlap and a prefix with stray low bits occur often. The consumer's ready line is randomized so that held results get checked during stalls.

// File: rtl/lpp_pkg.sv
package lpp_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'b00,
        SP_ACCREG    = 2'b01,
        SP_SECONDARY = 2'b10,
        SP_HOME      = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'b00,
        RES_PROT = 2'b01,
        RES_MODE = 2'b10
    } res_e;

    // Private bits: [0] primary, [1] secondary, [2] home
    typedef struct packed {
        logic       lap_en;
        logic       dat_on;
        space_e     space;
        logic [2:0] priv;
    } ctl_t;

    // Bit positions inside the exception-code word
    localparam int TEC_FETCH_BIT = 11;
    localparam int TEC_STORE_BIT = 10;
    localparam int TEC_LAP_BIT   = 7;
    localparam int TEC_SPACE_W   = 2;

    function automatic logic is_store(acc_e a);
        return a == ACC_STORE;
    endfunction

    function automatic logic space_private(ctl_t c);
        logic p;
        case (c.space)
            SP_PRIMARY:   p = c.priv[0];
            SP_SECONDARY: p = c.priv[1];
            SP_HOME:      p = c.priv[2];
            default:      p = 1'b0;
        endcase
        return p;
    endfunction

    function automatic logic space_unsupported(ctl_t c);
        return c.dat_on && (c.space == SP_ACCREG);
    endfunction

endpackage

// File: rtl/lpp_lowprot_check.sv
module lpp_lowprot_check
    import lpp_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_BYTES = 512,
    parameter int LOW_PAGES = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_e              acc,
    input  ctl_t              ctl,
    output logic              prot_fault,
    output logic              wr_inval,
    output logic              mode_err
);
    localparam int PG_W  = ADDR_W - PAGE_BITS;
    localparam int OFF_W = PAGE_BITS;

    logic [PG_W-1:0]      page_idx;
    logic [OFF_W-1:0]     page_off;
    logic [LOW_PAGES-1:0] page_hit;
    logic [LOW_PAGES-1:0] byte_hit;
    logic                 guard_on;

    assign page_idx = addr[ADDR_W-1:PAGE_BITS];
    assign page_off = addr[PAGE_BITS-1:0];

    // One comparator pair per guarded page
    for (genvar g = 0; g < LOW_PAGES; g++) begin : g_win
        assign page_hit[g] = (page_idx == PG_W'(g));
        assign byte_hit[g] = page_hit[g] && (page_off < OFF_W'(LOW_BYTES));
    end

    always_comb begin
        mode_err = space_unsupported(ctl);
        if (ctl.dat_on)
            guard_on = ctl.lap_en && !space_private(ctl) && !mode_err;
        else
            guard_on = ctl.lap_en;
        wr_inval   = guard_on && (|page_hit);
        prot_fault = guard_on && (|byte_hit) && is_store(acc);
    end

endmodule

// File: rtl/lpp_prefix_swap.sv
module lpp_prefix_swap #(
    parameter int ADDR_W   = 64,
    parameter int PFX_BITS = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam int HI_W = ADDR_W - PFX_BITS;

    logic [ADDR_W-1:0] pfx_al;
    logic              in_zero_area;
    logic              in_pfx_area;

    assign pfx_al       = {prefix[ADDR_W-1:PFX_BITS], {PFX_BITS{1'b0}}};
    assign in_zero_area = (addr[ADDR_W-1:PFX_BITS] == '0);
    assign in_pfx_area  = (addr[ADDR_W-1:PFX_BITS] == prefix[ADDR_W-1:PFX_BITS]);

    always_comb begin
        if (in_zero_area)
            abs_addr = addr + pfx_al;
        else if (in_pfx_area)
            abs_addr = {{HI_W{1'b0}}, addr[PFX_BITS-1:0]};
        else
            abs_addr = addr;
    end

endmodule

// File: rtl/lpp_tec_build.sv
module lpp_tec_build
    import lpp_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_e              acc,
    input  ctl_t              ctl,
    input  logic              lap_fault,
    output logic [ADDR_W-1:0] tec
);
    always_comb begin
        tec = '0;
        tec[ADDR_W-1:PAGE_BITS] = addr[ADDR_W-1:PAGE_BITS];
        if (is_store(acc))
            tec[TEC_STORE_BIT] = 1'b1;
        else
            tec[TEC_FETCH_BIT] = 1'b1;
        if (ctl.dat_on)
            tec[TEC_SPACE_W-1:0] = ctl.space;
        tec[TEC_LAP_BIT] = lap_fault;
    end

endmodule

// File: rtl/lowprot_prefix_unit.sv
module lowprot_prefix_unit
    import lpp_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_BYTES = 512,
    parameter int LOW_PAGES = 2,
    parameter int PFX_BITS  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_acc,
    input  logic              in_lap_en,
    input  logic              in_dat_on,
    input  logic [1:0]        in_space,
    input  logic              in_priv_pri,
    input  logic              in_priv_sec,
    input  logic              in_priv_home,
    input  logic [ADDR_W-1:0] in_prefix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_abs,
    output logic              out_fault,
    output logic [1:0]        out_code,
    output logic [ADDR_W-1:0] out_tec,
    output logic              out_wr_inval
);
    ctl_t              ctl;
    acc_e              acc;
    logic              prot_fault;
    logic              wr_inval;
    logic              mode_err;
    logic [ADDR_W-1:0] swapped;
    logic [ADDR_W-1:0] tec;
    res_e              res;
    logic [ADDR_W-1:0] abs_next;

    assign acc = acc_e'(in_acc);
    assign ctl = '{lap_en: in_lap_en,
                   dat_on: in_dat_on,
                   space:  space_e'(in_space),
                   priv:   {in_priv_home, in_priv_sec, in_priv_pri}};

    lpp_lowprot_check #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .LOW_BYTES (LOW_BYTES),
        .LOW_PAGES (LOW_PAGES)
    ) chk_i (
        .addr       (in_addr),
        .acc        (acc),
        .ctl        (ctl),
        .prot_fault (prot_fault),
        .wr_inval   (wr_inval),
        .mode_err   (mode_err)
    );

    lpp_prefix_swap #(
        .ADDR_W   (ADDR_W),
        .PFX_BITS (PFX_BITS)
    ) swp_i (
        .addr     (in_addr),
        .prefix   (in_prefix),
        .abs_addr (swapped)
    );

    lpp_tec_build #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) tec_i (
        .addr      (in_addr),
        .acc       (acc),
        .ctl       (ctl),
        .lap_fault (prot_fault),
        .tec       (tec)
    );

    // Unsupported space outranks the guard check
    always_comb begin
        if (mode_err)        res = RES_MODE;
        else if (prot_fault) res = RES_PROT;
        else                 res = RES_OK;
        abs_next = (res == RES_OK) ? swapped : '0;
    end

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            out_abs      <= abs_next;
            out_code     <= res;
            out_fault    <= (res != RES_OK);
            out_tec      <= tec;
            out_wr_inval <= wr_inval;
        end
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_abs) && $stable(out_tec) && $stable(out_code)); // R9

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R9

    AST_PROT_IMPLIES_STORE_INVAL: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_code == RES_PROT |-> out_tec[TEC_STORE_BIT] && out_wr_inval); // R4

    AST_TEC_MARK_ONLY_ON_PROT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tec[TEC_LAP_BIT] == (out_code == RES_PROT))); // R5

    AST_MODE_ERR_NO_INVAL: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_code == RES_MODE |-> !out_wr_inval && out_fault); // R7

endmodule

// File: tb/lowprot_prefix_unit_tb_top.sv
module lowprot_prefix_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_addr;
    logic [1:0]  in_acc;
    logic        in_lap_en, in_dat_on;
    logic [1:0]  in_space;
    logic        in_priv_pri, in_priv_sec, in_priv_home;
    logic [63:0] in_prefix;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_abs;
    logic        out_fault;
    logic [1:0]  out_code;
    logic [63:0] out_tec;
    logic        out_wr_inval;

    always #5 clk = ~clk;

    lowprot_prefix_unit dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_acc(in_acc),
        .in_lap_en(in_lap_en), .in_dat_on(in_dat_on), .in_space(in_space),
        .in_priv_pri(in_priv_pri), .in_priv_sec(in_priv_sec), .in_priv_home(in_priv_home),
        .in_prefix(in_prefix),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_abs(out_abs), .out_fault(out_fault), .out_code(out_code),
        .out_tec(out_tec), .out_wr_inval(out_wr_inval)
    );

    typedef struct {
        logic [63:0] addr;
        logic [63:0] prefix;
        logic [1:0]  acc;
        logic [1:0]  space;
        logic        lap, dat, pp, ps, ph;
    } stim_t;

    typedef struct {
        logic [63:0] abs_a;
        logic [63:0] tec;
        logic [1:0]  code;
        logic        fault;
        logic        winv;
        string       code_tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    bit   stall_en = 1;

    function automatic bit is_low(logic [63:0] a);
        return (a <= 64'd511) || (a >= 64'd4096 && a <= 64'd4607);
    endfunction

    function automatic exp_t model(stim_t s);
        exp_t        e;
        logic [63:0] page, pfx;
        bit          merr, en, prot, priv;
        page = s.addr & ~64'hFFF;
        pfx  = s.prefix & ~64'h1FFF;
        merr = s.dat && (s.space == 2'b01);
        case (s.space)
            2'b00:   priv = s.pp;
            2'b10:   priv = s.ps;
            2'b11:   priv = s.ph;
            default: priv = 1'b0;
        endcase
        en     = s.dat ? (s.lap && !priv) : s.lap;
        e.winv = !merr && en && is_low(page);
        prot   = !merr && en && is_low(s.addr) && (s.acc == 2'b01);
        e.code = merr ? 2'b10 : (prot ? 2'b01 : 2'b00);
        e.fault = (e.code != 2'b00);
        e.tec  = page | (s.dat ? {62'd0, s.space} : 64'd0)
               | ((s.acc == 2'b01) ? 64'h400 : 64'h800) | (prot ? 64'h80 : 64'd0);
        if (e.fault)
            e.abs_a = 64'd0;
        else if (s.addr < 64'h2000)
            e.abs_a = s.addr + pfx;
        else if (s.addr >= pfx && (s.addr - pfx) < 64'h2000)
            e.abs_a = s.addr - pfx;
        else
            e.abs_a = s.addr;
        e.code_tag = merr ? "R7" : (s.dat ? "R1 R2" : "R1 R3");
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then compare and update the model
    task automatic step(bit want, stim_t s, output bit accepted);
        @(negedge clk);
        out_ready    = stall_en ? (($urandom % 4) != 0) : 1'b1;
        in_valid     = want;
        in_addr      = s.addr;
        in_prefix    = s.prefix;
        in_acc       = s.acc;
        in_space     = s.space;
        in_lap_en    = s.lap;
        in_dat_on    = s.dat;
        in_priv_pri  = s.pp;
        in_priv_sec  = s.ps;
        in_priv_home = s.ph;
        #1;
        chk("R9", "out_valid", {63'd0, out_valid}, {63'd0, q.size() > 0});
        chk("R9", "in_ready", {63'd0, in_ready}, {63'd0, !out_valid || out_ready});
        if (out_valid && q.size() > 0) begin
            chk(q[0].code_tag, "code", {62'd0, out_code}, {62'd0, q[0].code});
            chk("R8", "fault", {63'd0, out_fault}, {63'd0, q[0].fault});
            chk(q[0].fault ? "R8" : "R6", "abs", out_abs, q[0].abs_a);
            chk("R5", "tec", out_tec, q[0].tec);
            chk("R4", "wr_inval", {63'd0, out_wr_inval}, {63'd0, q[0].winv});
            if (out_ready) void'(q.pop_front());
        end
        accepted = want && in_ready;
        if (accepted) q.push_back(model(s));
    endtask

    task automatic send(stim_t s);
        bit acc_ok;
        acc_ok = 0;
        while (!acc_ok) step(1'b1, s, acc_ok);
    endtask

    function automatic stim_t mk(logic [63:0] a, logic [1:0] acc, bit lap, bit dat,
                                 logic [1:0] sp, bit pp, bit ps, bit ph, logic [63:0] pfx);
        stim_t s;
        s.addr = a; s.acc = acc; s.lap = lap; s.dat = dat; s.space = sp;
        s.pp = pp; s.ps = ps; s.ph = ph; s.prefix = pfx;
        return s;
    endfunction

    function automatic stim_t rnd();
        stim_t       s;
        logic [63:0] edges [8];
        edges = '{64'd511, 64'd512, 64'd4095, 64'd4096, 64'd4607, 64'd4608, 64'h1FFF, 64'h2000};
        s.prefix = {51'd0, 13'($urandom_range(0, 6)) } << 13;
        if (($urandom % 8) == 0) s.prefix = s.prefix | 64'($urandom % 64'h2000);
        case ($urandom % 4)
            0: s.addr = 64'($urandom % 32'h2000);
            1: s.addr = edges[$urandom % 8];
            2: s.addr = (s.prefix & ~64'h1FFF) + 64'($urandom % 32'h2400);
            default: s.addr = {$urandom, $urandom};
        endcase
        s.acc   = 2'($urandom);
        s.space = 2'($urandom);
        s.lap   = ($urandom % 4) != 0;
        s.dat   = 1'($urandom);
        s.pp    = 1'($urandom);
        s.ps    = 1'($urandom);
        s.ph    = 1'($urandom);
        return s;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        stim_t idle;
        bit    dummy;
        idle = mk(64'd0, 2'b00, 0, 0, 2'b00, 0, 0, 0, 64'd0);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_addr = '0; in_prefix = '0; in_acc = '0; in_space = '0;
        in_lap_en = 0; in_dat_on = 0; in_priv_pri = 0; in_priv_sec = 0; in_priv_home = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10", "out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R10", "in_ready after reset", {63'd0, in_ready}, 64'd1);

        // R1 R3: window edges, real mode, guard on, prefix 0x6000
        send(mk(64'd0,    2'b01, 1, 0, 2'b00, 1, 1, 1, 64'h6000));
        send(mk(64'd511,  2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd512,  2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd4095, 2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd4096, 2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd4607, 2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd4608, 2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd8192, 2'b01, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        // R4: read and fetch in low window: no fault, inval set
        send(mk(64'd0,    2'b00, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd100,  2'b10, 1, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'd100,  2'b11, 1, 0, 2'b11, 0, 0, 0, 64'h6000));
        // R3: guard off
        send(mk(64'd0,    2'b01, 0, 0, 2'b00, 0, 0, 0, 64'h6000));
        // R2: private bit of the selected space only
        send(mk(64'd8,    2'b01, 1, 1, 2'b00, 1, 0, 0, 64'h6000));
        send(mk(64'd8,    2'b01, 1, 1, 2'b00, 0, 1, 1, 64'h6000));
        send(mk(64'd8,    2'b01, 1, 1, 2'b10, 0, 1, 0, 64'h6000));
        send(mk(64'd8,    2'b01, 1, 1, 2'b10, 1, 0, 1, 64'h6000));
        send(mk(64'd4100, 2'b01, 1, 1, 2'b11, 0, 0, 1, 64'h6000));
        send(mk(64'd4100, 2'b01, 1, 1, 2'b11, 1, 1, 0, 64'h6000));
        // R7: unsupported space with translation on; ignored with it off
        send(mk(64'd8,    2'b01, 1, 1, 2'b01, 0, 0, 0, 64'h6000));
        send(mk(64'h1234, 2'b00, 1, 1, 2'b01, 0, 0, 0, 64'h6000));
        send(mk(64'd8,    2'b01, 1, 0, 2'b01, 0, 0, 0, 64'h6000));
        // R6: swap both ways, pass-through, unaligned prefix, zero prefix
        send(mk(64'h1234, 2'b00, 0, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'h7000, 2'b00, 0, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'h8000, 2'b00, 0, 0, 2'b00, 0, 0, 0, 64'h6000));
        send(mk(64'h0ABC, 2'b10, 0, 0, 2'b00, 0, 0, 0, 64'h6FFF));
        send(mk(64'h1ABC, 2'b00, 0, 1, 2'b10, 0, 0, 0, 64'd0));

        // Random traffic with idle gaps
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 5) == 0) step(1'b0, idle, dummy);
            send(rnd());
        end

        stall_en = 0;
        repeat (4) step(1'b0, idle, dummy);
        chk("R9", "drained", 64'(q.size()), 64'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule